// File: doc/BRIEF.md
# Addressable LED Chain Transmitter

This block drives the single data wire of a daisy-chained string of addressable RGB LEDs. Colour values come in over a valid/ready stream, one pixel per transfer, each with an 8-bit green, red and blue component and a flag that marks the final pixel of a frame. Every pixel is sent as 24 serial bits. Each bit is a high pulse followed by a low time, and the width of the pulse carries the bit value. The first pixel of a frame is taken by the LED nearest the transmitter, and each LED passes later pixels on down the chain. Pixels must therefore be supplied in chain order.

After the flagged final pixel, the transmitter holds the line low for a programmable reset gap and raises `busy`. This makes every LED latch its colour and wait for a new frame. If the stream runs dry partway through a frame, the line rests low until more data arrives. A stall that outlasts the reset threshold ends the frame on the LED side, so the next pixel lands in the first LED again. All pulse widths and the gap length are clock-count parameters. The defaults suit a 50 MHz clock: about 0.4/0.85 µs for a 0, about 0.8/0.45 µs for a 1, and a gap longer than 50 µs.

Top module: `led_strip_tx`

## Requirements
- R1: While reset is applied and on the first cycle after it, `line_out` and `busy` are low and `pix_ready` is high (idle).
- R2: A 0 bit drives `line_out` high for exactly `T0_HIGH` cycles and then low for exactly `T0_LOW` cycles when the next bit follows without a stall.
- R3: A 1 bit drives `line_out` high for exactly `T1_HIGH` cycles and then low for exactly `T1_LOW` cycles when the next bit follows without a stall.
- R4: A pixel is the 24-bit word {green[7:0], red[7:0], blue[7:0]}. It is sent from bit 23 down to bit 0, so green bit 7 goes first and blue bit 0 goes last. Pixels leave in the order they were accepted.
- R5: A pixel is taken only on a cycle where `pix_valid` and `pix_ready` are both high, and the first high pulse of that pixel starts on the next cycle.
- R6: If the next pixel is already valid when the current non-final pixel ends, the low time of the current pixel's last bit is its nominal value and no extra gap is inserted.
- R7: While a pixel is being sent, `pix_ready` rises only in the final low cycle of its last bit. It is never high while `line_out` is high or while `busy` is high.
- R8: After the high pulse of the last bit of a pixel flagged `pix_last`, the line stays low with `busy` high and `pix_ready` low for exactly `GAP_CYC` cycles. Then `pix_ready` rises, so with a waiting pixel the low time is `GAP_CYC`+1 cycles.
- R9: When no pixel is offered, the line stays low and `pix_ready` stays high however long the stall lasts. The next accepted pixel then starts at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid | input | 1 | A pixel is offered |
| pix_ready | output | 1 | The transmitter takes the offered pixel this cycle |
| pix_green | input | COMP_W | Green component |
| pix_red | input | COMP_W | Red component |
| pix_blue | input | COMP_W | Blue component |
| pix_last | input | 1 | The offered pixel ends the frame |
| line_out | output | 1 | Serial data line to the first LED |
| busy | output | 1 | The reset gap is being driven |

## Verification
A wrong phase or timer state appears on the very next edge of `line_out` as a pulse whose width matches neither bit code, or as a low time that differs from the nominal value. The bench measures every interval to the cycle, so this is caught within one bit time. A shift-register or bit-index fault leaves the pulse widths correct but corrupts the word, and it is reported when that pixel's 24th bit completes. Faults in the final-pixel flag or the gap timer change the length of the `busy` run and the moment `pix_ready` returns, which the bench catches at the end of each frame.

// File: rtl/led_tx_pkg.sv
// Package: shared constants and types for the LED chain transmitter.
// Assumes three colour channels per pixel, sent green, red, blue.
package led_tx_pkg;

    // Number of colour channels in one pixel word.
    localparam int NUM_CH = 3;

    // Line phases of the transmitter.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2,
        PH_GAP  = 2'd3
    } tx_phase_e;

    // Larger of two integers, used for deriving counter widths.
    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/led_tx_timer.sv
// Module: loadable down-counter that times one line phase.
// Assumes the loaded value is the phase length minus one; zero marks the
// last cycle of the phase. The counter holds at zero once it gets there.
module led_tx_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             at_zero
);

    logic [CNT_W-1:0] remain;

    // Count the current phase down, reloading when a new phase starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign at_zero = (remain == '0);

endmodule

// File: rtl/led_tx_shift.sv
// Module: pixel word shift register with bit index.
// Assumes the MSB of the word goes out first. Presents the current bit, the
// bit after it, and a flag for the last bit of the word.
module led_tx_shift #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              advance,
    output logic              cur_bit,
    output logic              next_bit,
    output logic              final_bit
);

    localparam int IDX_W = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    logic [WORD_W-1:0] word_q;
    logic [IDX_W-1:0]  idx_q;

    // Hold the pixel being sent and move to the next bit on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            word_q <= load_word;
            idx_q  <= '0;
        end else if (advance) begin
            word_q <= {word_q[WORD_W-2:0], 1'b0};
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign cur_bit   = word_q[WORD_W-1];
    assign next_bit  = word_q[WORD_W-2];
    assign final_bit = (idx_q == LAST_IDX);

endmodule

// File: rtl/led_strip_tx.sv
// Module: addressable LED chain transmitter (top).
// Takes pixels over valid/ready and sends each as 24 pulse-width-coded bits,
// green then red then blue, MSB first. After a pixel flagged last it drives
// a low reset gap with busy high. Assumes every timing parameter is >= 1.
module led_strip_tx
    import led_tx_pkg::*;
#(
    parameter int COMP_W  = 8,
    parameter int T0_HIGH = 20,
    parameter int T0_LOW  = 42,
    parameter int T1_HIGH = 40,
    parameter int T1_LOW  = 22,
    parameter int GAP_CYC = 2600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    output logic              pix_ready,
    input  logic [COMP_W-1:0] pix_green,
    input  logic [COMP_W-1:0] pix_red,
    input  logic [COMP_W-1:0] pix_blue,
    input  logic              pix_last,
    output logic              line_out,
    output logic              busy
);

    localparam int WORD_W  = NUM_CH * COMP_W;
    localparam int MAX_BIT = max_int(max_int(T0_HIGH, T0_LOW), max_int(T1_HIGH, T1_LOW));
    localparam int MAX_CNT = max_int(MAX_BIT, GAP_CYC);
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    tx_phase_e         phase, phase_n;
    logic              line_q;
    logic              last_q;
    logic              accept;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              sh_load;
    logic              sh_adv;
    logic              cur_bit;
    logic              next_bit;
    logic              final_bit;
    logic [COMP_W-1:0] comp [NUM_CH];
    logic [WORD_W-1:0] in_word;

    // High-phase length minus one for a given bit value.
    function automatic logic [CNT_W-1:0] high_len(input logic b);
        return b ? CNT_W'(T1_HIGH - 1) : CNT_W'(T0_HIGH - 1);
    endfunction

    // Low-phase length minus one for a given bit value.
    function automatic logic [CNT_W-1:0] low_len(input logic b);
        return b ? CNT_W'(T1_LOW - 1) : CNT_W'(T0_LOW - 1);
    endfunction

    // Channel order on the line: green, red, blue.
    assign comp[0] = pix_green;
    assign comp[1] = pix_red;
    assign comp[2] = pix_blue;

    // Pack the channels into one word, first channel in the top bits.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_pack
        assign in_word[WORD_W-1-c*COMP_W -: COMP_W] = comp[c];
    end

    // Ready when idle, or in the final low cycle of a non-final pixel.
    assign pix_ready = (phase == PH_IDLE) ||
                       ((phase == PH_LOW) && tmr_zero && final_bit && !last_q);
    assign accept    = pix_valid && pix_ready;

    // Phase sequencing and the loads for the timer and shifter.
    always_comb begin
        phase_n  = phase;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_adv   = 1'b0;
        case (phase)
            PH_IDLE: begin
                if (accept) begin
                    phase_n  = PH_HIGH;
                    sh_load  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = high_len(in_word[WORD_W-1]);
                end
            end
            PH_HIGH: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (final_bit && last_q) begin
                        phase_n = PH_GAP;
                        tmr_val = CNT_W'(GAP_CYC - 1);
                    end else begin
                        phase_n = PH_LOW;
                        tmr_val = low_len(cur_bit);
                    end
                end
            end
            PH_LOW: begin
                if (tmr_zero) begin
                    if (!final_bit) begin
                        phase_n  = PH_HIGH;
                        sh_adv   = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = high_len(next_bit);
                    end else if (accept) begin
                        phase_n  = PH_HIGH;
                        sh_load  = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = high_len(in_word[WORD_W-1]);
                    end else begin
                        phase_n = PH_IDLE;
                    end
                end
            end
            PH_GAP: begin
                if (tmr_zero) begin
                    phase_n = PH_IDLE;
                end
            end
            default: phase_n = PH_IDLE;
        endcase
    end

    // Register the phase and the line level so the output has no glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            line_q <= 1'b0;
        end else begin
            phase  <= phase_n;
            line_q <= (phase_n == PH_HIGH);
        end
    end

    // Remember whether the pixel being sent closes the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else if (sh_load) begin
            last_q <= pix_last;
        end
    end

    led_tx_timer #(
        .CNT_W    (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .at_zero  (tmr_zero)
    );

    led_tx_shift #(
        .WORD_W    (WORD_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_word (in_word),
        .advance   (sh_adv),
        .cur_bit   (cur_bit),
        .next_bit  (next_bit),
        .final_bit (final_bit)
    );

    assign line_out = line_q;
    assign busy     = (phase == PH_GAP);

endmodule

// File: rtl/led_strip_tx_chk.sv
// Module: port-level checker for the LED chain transmitter, bound below.
// Measures high-pulse and busy-run lengths with counters rather than long
// delays, so large gap parameters do not unroll.
module led_strip_tx_chk
    import led_tx_pkg::*;
#(
    parameter int T0_HIGH = 20,
    parameter int T0_LOW  = 42,
    parameter int T1_HIGH = 40,
    parameter int T1_LOW  = 22,
    parameter int GAP_CYC = 2600
) (
    input logic clk,
    input logic rst_n,
    input logic pix_valid,
    input logic pix_ready,
    input logic line_out,
    input logic busy
);

    localparam int RUN_MAX = max_int(max_int(T0_HIGH, T1_HIGH), GAP_CYC) + 2;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);

    logic [RUN_W-1:0] hi_run;
    logic [RUN_W-1:0] busy_run;

    // Length of the current high pulse on the line.
    always_ff @(posedge clk) begin
        if (!rst_n)        hi_run <= '0;
        else if (line_out) hi_run <= hi_run + 1'b1;
        else               hi_run <= '0;
    end

    // Length of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!line_out && !busy && pix_ready));

    // R2 R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_out) |-> ((hi_run == RUN_W'(T0_HIGH)) || (hi_run == RUN_W'(T1_HIGH))));

    // R5
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready) |=> line_out);

    // R7
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> (!line_out && !busy));

    // R8
    gap_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ((busy_run == RUN_W'(GAP_CYC)) && pix_ready && !line_out));

    // R8
    gap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !line_out);

endmodule

bind led_strip_tx led_strip_tx_chk #(
    .T0_HIGH   (T0_HIGH),
    .T0_LOW    (T0_LOW),
    .T1_HIGH   (T1_HIGH),
    .T1_LOW    (T1_LOW),
    .GAP_CYC   (GAP_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .line_out  (line_out),
    .busy      (busy)
);

// File: tb/led_strip_tx_bench.sv
// Bench: drives pixels, decodes the line back into words, and checks pulse
// widths, low times, gap length and word order against bench functions.
module led_strip_tx_bench;

    localparam int T0H = 3;
    localparam int T0L = 7;
    localparam int T1H = 7;
    localparam int T1L = 3;
    localparam int GAP = 40;
    localparam int PIX_CYC = 24 * 10;

    typedef struct packed {
        logic [23:0] word;
        logic        last;
        logic        late;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_valid = 1'b0;
    logic       pix_ready;
    logic [7:0] pix_green = '0;
    logic [7:0] pix_red = '0;
    logic [7:0] pix_blue = '0;
    logic       pix_last = 1'b0;
    logic       line_out;
    logic       busy;

    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    // monitor state
    logic        prev_line = 1'b0;
    int          run_len = 0;
    int          bit_cnt = 0;
    logic [23:0] rx_word = '0;
    logic        last_bit = 1'b0;
    bit          have_bit = 1'b0;
    bit          pix_end = 1'b0;
    bit          pix_end_last = 1'b0;
    logic        prev_busy = 1'b0;
    int          busy_len = 0;
    int          ready_hi_viol = 0;
    int          busy_viol = 0;

    always #10 clk = ~clk;

    led_strip_tx #(
        .COMP_W    (8),
        .T0_HIGH   (T0H),
        .T0_LOW    (T0L),
        .T1_HIGH   (T1H),
        .T1_LOW    (T1L),
        .GAP_CYC   (GAP)
    ) u_led_strip_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .pix_ready (pix_ready),
        .pix_green (pix_green),
        .pix_red   (pix_red),
        .pix_blue  (pix_blue),
        .pix_last  (pix_last),
        .line_out  (line_out),
        .busy      (busy)
    );

    function automatic int exp_high(input logic b);
        return b ? T1H : T0H;
    endfunction

    function automatic int exp_low(input logic b);
        return b ? T1L : T0L;
    endfunction

    function automatic logic [23:0] pack_grb(input logic [7:0] g, input logic [7:0] r,
                                             input logic [7:0] b);
        return {g, r, b};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Line decoder and interval checks, sampled away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_line = 1'b0;
            run_len   = 0;
            bit_cnt   = 0;
            have_bit  = 1'b0;
            prev_busy = 1'b0;
            busy_len  = 0;
        end else begin
            if (line_out && pix_ready) ready_hi_viol++;
            if (busy && (line_out || pix_ready)) busy_viol++;
            if (busy) busy_len++;
            else if (prev_busy) begin
                check(busy_len == GAP, "R8 busy run length", busy_len, GAP);
                check(pix_ready == 1'b1, "R8 ready after gap", pix_ready, 1);
                busy_len = 0;
            end
            prev_busy = busy;

            if (line_out == prev_line) begin
                run_len++;
            end else begin
                if (prev_line) begin
                    logic b;
                    b = (run_len == T1H);
                    if (run_len == T1H)
                        check(1'b1, "R3 high width", run_len, T1H);
                    else
                        check(run_len == T0H, "R2 high width", run_len, T0H);
                    rx_word  = {rx_word[22:0], b};
                    last_bit = b;
                    have_bit = 1'b1;
                    bit_cnt++;
                    pix_end  = 1'b0;
                    if (bit_cnt == 24) begin
                        exp_t e;
                        bit_cnt = 0;
                        pix_end = 1'b1;
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R4 unexpected pixel", int'(rx_word), 0);
                            pix_end_last = 1'b0;
                        end else begin
                            e = exp_q.pop_front();
                            check(rx_word == e.word, "R4 pixel word", int'(rx_word), int'(e.word));
                            pix_end_last = e.last;
                        end
                    end
                end else if (have_bit) begin
                    bit nxt_late;
                    nxt_late = (exp_q.size() > 0) ? exp_q[0].late : 1'b1;
                    if (!pix_end) begin
                        check(run_len == exp_low(last_bit),
                              last_bit ? "R3 low width" : "R2 low width",
                              run_len, exp_low(last_bit));
                    end else if (pix_end_last) begin
                        if (nxt_late)
                            check(run_len >= GAP + 1, "R8 gap low min", run_len, GAP + 1);
                        else
                            check(run_len == GAP + 1, "R8 gap low exact", run_len, GAP + 1);
                    end else begin
                        if (nxt_late)
                            check(run_len >= exp_low(last_bit), "R9 stalled low", run_len,
                                  exp_low(last_bit));
                        else
                            check(run_len == exp_low(last_bit), "R6 back-to-back low", run_len,
                                  exp_low(last_bit));
                    end
                end
                run_len   = 1;
                prev_line = line_out;
            end
        end
    end

    // Offer one pixel after a delay and wait until it is taken.
    task automatic send(input logic [23:0] w, input logic last, input int delay);
        exp_t e;
        repeat (delay) @(negedge clk);
        pix_green = w[23:16];
        pix_red   = w[15:8];
        pix_blue  = w[7:0];
        pix_last  = last;
        pix_valid = 1'b1;
        e.word = pack_grb(w[23:16], w[15:8], w[7:0]);
        e.last = last;
        e.late = (delay > 0);
        while (!pix_ready) @(negedge clk);
        exp_q.push_back(e);
        @(negedge clk);
        pix_valid = 1'b0;
        pix_green = 8'hxx;
        pix_red   = 8'hxx;
        pix_blue  = 8'hxx;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1 idle outputs under reset
        check(line_out == 1'b0, "R1 line low in reset", line_out, 0);
        check(busy == 1'b0, "R1 busy low in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pix_ready == 1'b1, "R1 ready after reset", pix_ready, 1);
        check(line_out == 1'b0, "R1 line low after reset", line_out, 0);

        // R2 all-zero pixel, R3 all-one pixel, R4 mixed pattern
        send(24'h000000, 1'b1, 0);
        send(24'hFFFFFF, 1'b1, 0);
        send(24'hA55A3C, 1'b0, 0);
        send(24'h81C300, 1'b0, 0);
        send(24'h0F1E2D, 1'b1, 0);

        // R9 stall past a whole pixel and past the reset threshold
        send(24'h123456, 1'b0, 0);
        repeat (PIX_CYC + GAP + 20) @(negedge clk);
        check(line_out == 1'b0, "R9 line low in stall", line_out, 0);
        check(pix_ready == 1'b1, "R9 ready held in stall", pix_ready, 1);
        send(24'h654321, 1'b0, 1);
        send(24'hC0FFEE, 1'b1, 0);

        // random traffic with random frame ends and delays
        for (int i = 0; i < 30; i++) begin
            logic [23:0] w;
            int          d;
            w = 24'($urandom);
            d = ($urandom % 4 == 0) ? int'($urandom % 12) : 0;
            send(w, ($urandom % 4) == 0, d);
        end
        send(24'h5A5A5A, 1'b1, 0);

        repeat (PIX_CYC + 3 * GAP) @(negedge clk);
        check(exp_q.size() == 0, "R4 all pixels decoded", exp_q.size(), 0);
        check(bit_cnt == 0, "R4 no partial pixel", bit_cnt, 0);
        check(ready_hi_viol == 0, "R7 ready while line high", ready_hi_viol, 0);
        check(busy_viol == 0, "R8 line or ready during gap", busy_viol, 0);
        check(!busy && pix_ready && !line_out, "R1 idle at end",
              {busy, pix_ready, line_out}, 3'b010);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R5 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule